// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller

This block turns a bank of twelve general-purpose input pins into interrupt sources. Each pin goes through a two-flop synchronizer. A 3-bit trigger code per pin then selects what counts as an event on that pin: a rising edge, a falling edge, either edge, an active-low level or an active-high level. An event sets the pin's pending bit only while the pin is enabled. A separate mask decides whether a pending pin drives the single combined interrupt line.

Software works through a small word-addressed register bus. The bus carries an address, write data, a write strobe and a combinational read-data return. Through it software enables pins, reads the pending status and clears pending bits by writing ones. It masks and unmasks pins through two write-one registers. It programs the trigger codes in two mode registers, which pack the codes into 4-bit slots.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Word addresses on `bus_addr`:
  - 0 is the enable register (read/write).
  - 1 is the pending status (read only).
  - 2 is the clear register.
  - 3 is mask-set.
  - 4 is mask-clear.
  - 5 is mode-low.
  - 6 is mode-high.
  - Address 7 reads zero and writes to it change nothing. Per-pin bits sit in bits 11:0, bit n for pin n.
- R2: After reset:
  - enable is 0x000 and status is 0x000.
  - The mask reads 0xFFF, so every pin is masked.
  - Both mode registers read zero and `irq_out` is low.
- R3: Pin n's trigger code sits in the low 3 bits of a 4-bit slot:
  - Pins 0 to 7 are in mode-low at bit 4n.
  - Pins 8 to 11 are in mode-high at bit 4(n-8).
  - The top bit of each slot, and mode-high bits 31:16, read as zero.
- R4: Code 000 latches pending on a falling edge (1 to 0) of the synchronized pin.
- R5: Code 001 latches pending on a rising edge (0 to 1).
- R6: Code 100 latches pending on either edge.
- R7: Code 010 latches while the pin is low and code 011 latches while it is high. In these level codes a cleared bit is set again on the next clock if the level is still present.
- R8: Codes 101, 110 and 111 never latch pending.
- R9: Timing of an edge from a pin change:
  - The pin change passes two synchronizer flops.
  - The edge is found against the synchronized value one clock earlier.
  - The pending bit is set by the third rising clock edge after the pin changes, and not before.
- R10: Writing a 1 to a clear-register bit clears that pin's pending bit. A 0 bit has no effect. The clear register reads zero. A cleared bit in an edge code stays clear until the next qualifying edge.
- R11: When a clear and a new detection on the same pin meet in the same clock, the pending bit ends up set.
- R12: Pending is latched only while the pin's enable bit is 1. It is latched whether or not the pin is masked.
- R13: Writing ones to mask-set masks those pins and writing ones to mask-clear unmasks them. Zero bits leave the mask unchanged. The mask reads back at both addresses 3 and 4, with a 1 meaning masked.
- R14: `irq_out` is high exactly when some pin is pending, enabled and unmasked, with no added register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 12 | Asynchronous pin inputs, bit n is pin n |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per clock |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The hardest situation to reach from the ports is a clear write landing in exactly the clock in which a freshly synchronized edge is being latched. The stimulus lines this up by changing one pin on a falling clock edge. It then counts two rising edges through the synchronizer and holds the clear strobe across the third. A sweep covers every pin against all eight trigger codes. In each case the pin moves through rise, hold, fall and hold, with a clear issued together with every change. This reaches the level re-latch after a clear, and the old and new level overlap during the synchronizer delay, for every slot position in both mode registers.

// File: rtl/gpio_irq_pkg.sv
// Shared constants for the GPIO pin interrupt controller.
// Assumes a 3-bit word address and a 32-bit data bus.
package gpio_irq_pkg;

    localparam int ADDR_W        = 3;
    localparam int DATA_W        = 32;
    localparam int CODE_W        = 3;
    localparam int SLOT_W        = 4;
    localparam int SLOTS_PER_REG = DATA_W / SLOT_W;

    // Trigger codes; any other value disables detection.
    typedef enum logic [CODE_W-1:0] {
        TRIG_FALL = 3'b000,
        TRIG_RISE = 3'b001,
        TRIG_LOW  = 3'b010,
        TRIG_HIGH = 3'b011,
        TRIG_ANY  = 3'b100
    } trig_e;

    // Register word addresses.
    localparam logic [ADDR_W-1:0] A_ENABLE  = 3'd0;
    localparam logic [ADDR_W-1:0] A_STATUS  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CLEAR   = 3'd2;
    localparam logic [ADDR_W-1:0] A_MSET    = 3'd3;
    localparam logic [ADDR_W-1:0] A_MCLR    = 3'd4;
    localparam logic [ADDR_W-1:0] A_MODE_LO = 3'd5;
    localparam logic [ADDR_W-1:0] A_MODE_HI = 3'd6;

endpackage

// File: rtl/gpio_irq_sync.sv
// Two-flop synchronizer per pin, plus a third flop holding the
// synchronized value from one clock earlier for edge comparison.
// Assumes pins are quasi-static relative to clk (no debounce here).
module gpio_irq_sync #(
    parameter int NPINS = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_async,
    output logic [NPINS-1:0] pin_cur,
    output logic [NPINS-1:0] pin_prev
);

    logic [NPINS-1:0] meta_q;
    logic [NPINS-1:0] cur_q;
    logic [NPINS-1:0] prev_q;

    // Shift the pin samples through the synchronizer and history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_async;
            cur_q  <= meta_q;
            prev_q <= cur_q;
        end
    end

    assign pin_cur  = cur_q;
    assign pin_prev = prev_q;

endmodule

// File: rtl/gpio_irq_detect.sv
// Per-pin event decoder: turns the synchronized pin value, its
// previous value and the pin's trigger code into a one-clock event
// (edge codes) or a continuous event (level codes).
// Assumes codes outside the trigger enum mean "detection off".
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 12
) (
    input  logic [NPINS-1:0]        pin_cur,
    input  logic [NPINS-1:0]        pin_prev,
    input  logic [NPINS*CODE_W-1:0] mode_flat,
    output logic [NPINS-1:0]        event_vec
);

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic [CODE_W-1:0] code;
        logic              rise;
        logic              fall;

        assign code = mode_flat[p*CODE_W +: CODE_W];
        assign rise = pin_cur[p] & ~pin_prev[p];
        assign fall = ~pin_cur[p] & pin_prev[p];

        // Select the event condition named by this pin's code.
        always_comb begin
            case (code)
                TRIG_FALL: event_vec[p] = fall;
                TRIG_RISE: event_vec[p] = rise;
                TRIG_ANY:  event_vec[p] = rise | fall;
                TRIG_LOW:  event_vec[p] = ~pin_cur[p];
                TRIG_HIGH: event_vec[p] = pin_cur[p];
                default:   event_vec[p] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_irq_regs.sv
// Register file: enable, pending, mask and per-pin trigger codes,
// with a combinational read mux. Pending is set by enabled events
// and cleared by write-one; a same-clock event overrides the clear.
// Assumes NPINS is between SLOTS_PER_REG+1 and 2*SLOTS_PER_REG.
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    input  logic                    bus_we,
    input  logic [NPINS-1:0]        event_vec,
    output logic [DATA_W-1:0]       bus_rdata,
    output logic [NPINS-1:0]        en_q,
    output logic [NPINS-1:0]        pend_q,
    output logic [NPINS-1:0]        mask_q,
    output logic [NPINS*CODE_W-1:0] mode_flat
);

    localparam int PAD_W = DATA_W - NPINS;

    logic [NPINS-1:0]  wbits;
    logic [NPINS-1:0]  clr_vec;
    logic [CODE_W-1:0] mode_q [NPINS];
    logic [DATA_W-1:0] mode_lo_rd;
    logic [DATA_W-1:0] mode_hi_rd;
    logic              wdata_unused;

    assign wbits        = bus_wdata[NPINS-1:0];
    assign clr_vec      = (bus_we && bus_addr == A_CLEAR) ? wbits : '0;
    assign wdata_unused = ^bus_wdata;

    // Enable register: plain read/write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (bus_we && bus_addr == A_ENABLE)
            en_q <= wbits;
    end

    // Mask register: write-one-to-set and write-one-to-clear ports.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '1;
        else if (bus_we && bus_addr == A_MSET)
            mask_q <= mask_q | wbits;
        else if (bus_we && bus_addr == A_MCLR)
            mask_q <= mask_q & ~wbits;
    end

    // Pending register: clear by write-one, enabled events win.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else
            pend_q <= (pend_q & ~clr_vec) | (event_vec & en_q);
    end

    // Trigger code storage, one 3-bit field per pin in its slot.
    for (genvar p = 0; p < NPINS; p++) begin : g_mode
        localparam int               OFF = (p % SLOTS_PER_REG) * SLOT_W;
        localparam logic [ADDR_W-1:0] SEL = (p < SLOTS_PER_REG) ? A_MODE_LO : A_MODE_HI;

        // Load this pin's code when its mode register is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mode_q[p] <= '0;
            else if (bus_we && bus_addr == SEL)
                mode_q[p] <= bus_wdata[OFF +: CODE_W];
        end
    end

    // Pack stored codes into readback images and the flat code bus.
    always_comb begin
        mode_lo_rd = '0;
        mode_hi_rd = '0;
        mode_flat  = '0;
        for (int p = 0; p < NPINS; p++) begin
            if (p < SLOTS_PER_REG)
                mode_lo_rd[(p % SLOTS_PER_REG)*SLOT_W +: CODE_W] = mode_q[p];
            else
                mode_hi_rd[(p % SLOTS_PER_REG)*SLOT_W +: CODE_W] = mode_q[p];
            mode_flat[p*CODE_W +: CODE_W] = mode_q[p];
        end
    end

    // Read mux keyed by word address.
    always_comb begin
        case (bus_addr)
            A_ENABLE:  bus_rdata = {{PAD_W{1'b0}}, en_q};
            A_STATUS:  bus_rdata = {{PAD_W{1'b0}}, pend_q};
            A_MSET,
            A_MCLR:    bus_rdata = {{PAD_W{1'b0}}, mask_q};
            A_MODE_LO: bus_rdata = mode_lo_rd;
            A_MODE_HI: bus_rdata = mode_hi_rd;
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_irq_ctrl.sv
// Top of the GPIO pin interrupt controller: synchronizer, event
// decoder and register file, with a combinational interrupt OR.
// Assumes one bus write per clock and asynchronous pin inputs.
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);

    logic [NPINS-1:0]        pin_cur;
    logic [NPINS-1:0]        pin_prev;
    logic [NPINS-1:0]        event_vec;
    logic [NPINS-1:0]        en_q;
    logic [NPINS-1:0]        pend_q;
    logic [NPINS-1:0]        mask_q;
    logic [NPINS*CODE_W-1:0] mode_flat;

    gpio_irq_sync #(.NPINS(NPINS)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pin_in),
        .pin_cur   (pin_cur),
        .pin_prev  (pin_prev)
    );

    gpio_irq_detect #(.NPINS(NPINS)) u_detect (
        .pin_cur   (pin_cur),
        .pin_prev  (pin_prev),
        .mode_flat (mode_flat),
        .event_vec (event_vec)
    );

    gpio_irq_regs #(.NPINS(NPINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .event_vec (event_vec),
        .bus_rdata (bus_rdata),
        .en_q      (en_q),
        .pend_q    (pend_q),
        .mask_q    (mask_q),
        .mode_flat (mode_flat)
    );

    // Combined request: any pending, enabled and unmasked pin.
    assign irq_out = |(pend_q & en_q & ~mask_q);

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
// Assertion checker for gpio_irq_ctrl, attached with bind below.
// Observes the bus, the interrupt line and the register-file state.
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NPINS-1:0]  wdata,
    input logic              bus_we,
    input logic              irq_out,
    input logic [NPINS-1:0]  pend,
    input logic [NPINS-1:0]  en,
    input logic [NPINS-1:0]  mask,
    input logic [NPINS-1:0]  evt
);

    // R10 R11
    clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CLEAR) |=>
            ((pend & $past(wdata) & ~($past(evt) & $past(en))) == '0));

    // R12
    new_pend_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & ~$past(pend) & ~($past(evt) & $past(en))) == '0));

    // R13
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_MSET) |=> ((mask & $past(wdata)) == $past(wdata)));

    // R13
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_MCLR) |=> ((mask & $past(wdata)) == '0));

    // R13
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && (bus_addr == A_MSET || bus_addr == A_MCLR)) |=> $stable(mask));

    // R14
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((en & ~mask) == '0) |-> !irq_out);

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .wdata    (bus_wdata[NPINS-1:0]),
    .bus_we   (bus_we),
    .irq_out  (irq_out),
    .pend     (pend_q),
    .en       (en_q),
    .mask     (mask_q),
    .evt      (event_vec)
);

// File: tb/gpio_irq_ctrl_test.sv
// Self-checking bench: directed register and timing cases, then a
// sweep of every pin against every trigger code.
module gpio_irq_ctrl_test;

    localparam int NP = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] pin_in = '0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    gpio_irq_ctrl #(.NPINS(NP)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        bus_we   = 1'b0;
        #1 v = bus_rdata;
    endtask

    function automatic logic hit(input int code, input logic o, input logic n);
        case (code)
            0: return o & ~n;
            1: return ~o & n;
            4: return o ^ n;
            2: return ~o | ~n;
            3: return o | n;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string tag(input int code);
        case (code)
            0: return "R4";
            1: return "R5";
            4: return "R6";
            2, 3: return "R7";
            default: return "R8";
        endcase
    endfunction

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state, R1 unmapped address, R10 clear reads zero
        rd(3'd0, v); check("R2 enable", v, 32'h0);
        rd(3'd1, v); check("R2 status", v, 32'h0);
        rd(3'd3, v); check("R2 R13 mask@3", v, 32'hFFF);
        rd(3'd4, v); check("R13 mask@4", v, 32'hFFF);
        rd(3'd5, v); check("R2 mode-low", v, 32'h0);
        rd(3'd6, v); check("R2 mode-high", v, 32'h0);
        check("R2 irq", {31'd0, irq_out}, 32'h0);
        rd(3'd2, v); check("R10 clear reads 0", v, 32'h0);
        rd(3'd7, v); check("R1 addr7 reads 0", v, 32'h0);

        // R3 mode slot layout
        wr(3'd5, 32'hFFFF_FFFF); rd(3'd5, v); check("R3 mode-low ones", v, 32'h7777_7777);
        wr(3'd6, 32'hFFFF_FFFF); rd(3'd6, v); check("R3 mode-high ones", v, 32'h0000_7777);
        wr(3'd5, 32'h1234_5670); rd(3'd5, v); check("R3 mode-low pattern", v, 32'h1234_5670);
        wr(3'd6, 32'hABCD_3210); rd(3'd6, v); check("R3 mode-high pattern", v, 32'h0000_3210);
        wr(3'd7, 32'hFFFF_FFFF);
        rd(3'd0, v); check("R1 addr7 write ignored (enable)", v, 32'h0);
        rd(3'd5, v); check("R1 addr7 write ignored (mode)", v, 32'h1234_5670);

        // R12 enable gating, R10 clear behaviour, R14 combining
        wr(3'd5, 32'h1111_1111); wr(3'd6, 32'h0000_1111);
        pin_in = 12'hFFF; repeat (5) @(negedge clk);
        rd(3'd1, v); check("R12 disabled pins not latched", v, 32'h0);
        wr(3'd0, 32'hFFF); repeat (4) @(negedge clk);
        rd(3'd1, v); check("R12 no edge after enable", v, 32'h0);
        pin_in = 12'h000; repeat (5) @(negedge clk);
        rd(3'd1, v); check("R5 falling ignored in rise code", v, 32'h0);
        pin_in = 12'hFFF; repeat (5) @(negedge clk);
        rd(3'd1, v); check("R12 latched while masked", v, 32'hFFF);
        check("R14 masked no irq", {31'd0, irq_out}, 32'h0);
        wr(3'd2, 32'h0); rd(3'd1, v); check("R10 zero clear no effect", v, 32'hFFF);
        wr(3'd2, 32'h00F); rd(3'd1, v); check("R10 partial clear", v, 32'hFF0);
        repeat (4) @(negedge clk);
        rd(3'd1, v); check("R10 edge stays clear", v, 32'hFF0);
        wr(3'd4, 32'h010); #1 check("R14 irq on unmask", {31'd0, irq_out}, 32'h1);
        wr(3'd4, 32'h0); rd(3'd3, v); check("R13 zero mask-clear no effect", v, 32'hFEF);
        wr(3'd3, 32'h0); rd(3'd4, v); check("R13 zero mask-set no effect", v, 32'hFEF);
        wr(3'd2, 32'h010); #1 check("R14 irq drops on clear", {31'd0, irq_out}, 32'h0);
        wr(3'd3, 32'h010); rd(3'd3, v); check("R13 mask-set", v, 32'hFFF);
        pin_in = 12'h000; repeat (5) @(negedge clk);
        wr(3'd2, 32'hFFF);

        // R9 latency: pin 0 rises, pending on the third clock edge
        @(negedge clk); pin_in[0] = 1'b1;
        @(negedge clk); #1 rd(3'd1, v);
        // rd waited one more negedge: now past two posedges
        check("R9 not set after two edges", v & 32'h1, 32'h0);
        @(negedge clk); #1 check("R9 set after third edge", bus_rdata & 32'h1, 32'h1);

        // R11 clear held across the latching edge of pin 1
        @(negedge clk); pin_in[1] = 1'b1;
        @(negedge clk);
        @(negedge clk); bus_addr = 3'd2; bus_wdata = 32'h2; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
        rd(3'd1, v); check("R11 detection beats clear", v & 32'h2, 32'h2);
        wr(3'd2, 32'h3); rd(3'd1, v); check("R10 plain clear", v, 32'h0);
        pin_in = 12'h000; repeat (5) @(negedge clk);
        wr(3'd2, 32'hFFF);

        // Sweep: every pin against every trigger code (R4-R8, R13, R14)
        for (int p = 0; p < NP; p++) begin
            for (int code = 0; code < 8; code++) begin
                logic [31:0] lo;
                logic [31:0] hi;
                logic        old;
                lo = 32'h7777_7777;
                hi = 32'h0000_7777;
                if (p < 8) lo[p*4 +: 4] = code[3:0];
                else       hi[(p-8)*4 +: 4] = code[3:0];
                wr(3'd0, 32'h0);
                wr(3'd5, lo);
                wr(3'd6, hi);
                wr(3'd2, 32'hFFF);
                wr(3'd0, 32'h1 << p);
                repeat (3) @(negedge clk);
                old = 1'b0;
                for (int s = 0; s < 4; s++) begin
                    logic nv;
                    logic e;
                    nv = (s < 2);
                    e  = hit(code, old, nv);
                    @(negedge clk);
                    pin_in[p] = nv;
                    bus_addr  = 3'd2;
                    bus_wdata = 32'hFFF;
                    bus_we    = 1'b1;
                    @(negedge clk); bus_we = 1'b0;
                    repeat (3) @(negedge clk);
                    rd(3'd1, v);
                    check(tag(code), v, {31'd0, e} << p);
                    check("R14 masked", {31'd0, irq_out}, 32'h0);
                    wr(3'd4, 32'h1 << p);
                    #1 check("R14 unmasked", {31'd0, irq_out}, {31'd0, e});
                    wr(3'd3, 32'h1 << p);
                    old = nv;
                end
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule